// File: doc/BRIEF.md
# Streaming UTF-8 Byte Serializer

This block turns Unicode code points into a UTF-8 byte stream. A code point comes in on a valid/ready input channel. The block works out how many bytes its encoding needs, which is one to four depending on the magnitude of the value. It then sends those bytes one at a time on a valid/ready output channel, starting with the lead byte. The final byte of each character is flagged so that downstream logic can find character boundaries without decoding.

Values above the largest legal code point produce no output bytes. Instead, a one-cycle error pulse is raised. The input channel accepts only one character at a time: it stays closed until the last byte of the current character has been taken downstream.

Top module: `utf8_byte_serializer`

## Requirements
- R1: A code point below 0x80 produces exactly one byte equal to the code point, with bit 7 clear and `byte_last` high.
- R2: A code point from 0x80 to 0x7FF produces two bytes. The first is 110 followed by bits 10..6 of the code point. The second is 10 followed by bits 5..0.
- R3: A code point from 0x800 to 0xFFFF produces three bytes. The first is 1110 followed by bits 15..12. Each of the other two is 10 followed by 6 code point bits.
- R4: A code point from 0x10000 to MAX_CP (0x10FFFF by default) produces four bytes. The first is 11110 followed by bits 20..18. Each of the other three is 10 followed by 6 code point bits.
- R5: Every byte of a multi-byte encoding has bit 7 set. The lead byte starts with 11 and every following byte starts with 10.
- R6: Bytes leave most significant group first. Code point 0x4EAC yields 0xE4, 0xBA, 0xAC in that order.
- R7: A code point above MAX_CP is accepted but produces no bytes. `range_err` is high for one cycle, in the cycle after acceptance, and the input is ready again in that same cycle.
- R8: `cp_ready` is low from the cycle after a legal code point is accepted until its last byte is taken. It is high again in the cycle after that handshake.
- R9: While `byte_valid` is high and `byte_ready` is low, `byte_valid`, `byte_data` and `byte_last` hold their values into the next cycle.
- R10: After reset, `cp_ready` is high, and `byte_valid` and `range_err` are low.
- R11: `byte_last` is high on the final byte of each character and low on every other byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cp_valid | input | 1 | Code point offered |
| cp_data | input | CP_W | Code point value |
| cp_ready | output | 1 | Block can take a code point |
| byte_valid | output | 1 | Output byte present |
| byte_data | output | 8 | Output byte |
| byte_last | output | 1 | Output byte ends a character |
| byte_ready | input | 1 | Downstream takes the byte |
| range_err | output | 1 | One-cycle pulse for an out-of-range code point |

## Verification
The bench uses the default parameters, CP_W of 21 and MAX_CP of 0x10FFFF, because these already bring every range boundary within reach.

Every code point in the one- and two-byte ranges is sent. The three- and four-byte ranges are swept with strides that hit both edges of each range, and several values above the limit are sent as well. Expected bytes come from arithmetic division of the code point by powers of 64.

Backpressure is applied on a rotating cycle pattern so that the hold and ready-gap behaviour is exercised on every encoding length.

// File: rtl/utf8_ser_pkg.sv
package utf8_ser_pkg;
  localparam int BYTE_W    = 8;
  localparam int MAX_BYTES = 4;
  localparam int FRAME_W   = MAX_BYTES * BYTE_W;
  localparam int CNT_W     = $clog2(MAX_BYTES + 1);
  localparam int GRP_W     = 6;
  localparam int CONT_N    = MAX_BYTES - 1;
endpackage

// File: rtl/utf8_len_classify.sv
module utf8_len_classify
  import utf8_ser_pkg::*;
#(
  parameter int              CP_W   = 21,
  parameter logic [CP_W-1:0] MAX_CP = CP_W'(21'h10FFFF)
) (
  input  logic [CP_W-1:0]  cp_i,
  output logic [CNT_W-1:0] nbytes_o,
  output logic             too_big_o
);
  localparam logic [CP_W-1:0] LIM1 = CP_W'(1) << 7;
  localparam logic [CP_W-1:0] LIM2 = CP_W'(1) << 11;
  localparam logic [CP_W-1:0] LIM3 = CP_W'(1) << 16;

  always_comb begin
    too_big_o = 1'b0;
    if (cp_i < LIM1)       nbytes_o = CNT_W'(1);
    else if (cp_i < LIM2)  nbytes_o = CNT_W'(2);
    else if (cp_i < LIM3)  nbytes_o = CNT_W'(3);
    else if (cp_i <= MAX_CP) nbytes_o = CNT_W'(4);
    else begin
      nbytes_o  = '0;
      too_big_o = 1'b1;
    end
  end
endmodule

// File: rtl/utf8_byte_former.sv
module utf8_byte_former
  import utf8_ser_pkg::*;
#(
  parameter int CP_W = 21
) (
  input  logic [CP_W-1:0]    cp_i,
  input  logic [CNT_W-1:0]   nbytes_i,
  output logic [FRAME_W-1:0] frame_o
);
  logic [BYTE_W-1:0] cont [CONT_N];

  for (genvar k = 0; k < CONT_N; k++) begin : g_cont
    assign cont[k] = {2'b10, cp_i[k*GRP_W +: GRP_W]};
  end

  always_comb begin
    case (nbytes_i)
      CNT_W'(1): frame_o = {1'b0, cp_i[6:0], {(FRAME_W-BYTE_W){1'b0}}};
      CNT_W'(2): frame_o = {3'b110, cp_i[10:6], cont[0], {(FRAME_W-2*BYTE_W){1'b0}}};
      CNT_W'(3): frame_o = {4'b1110, cp_i[15:12], cont[1], cont[0], {(FRAME_W-3*BYTE_W){1'b0}}};
      CNT_W'(4): frame_o = {5'b11110, cp_i[20:18], cont[2], cont[1], cont[0]};
      default:   frame_o = '0;
    endcase
  end
endmodule

// File: rtl/utf8_tx_shifter.sv
module utf8_tx_shifter
  import utf8_ser_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               load_i,
  input  logic               load_err_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [CNT_W-1:0]   nbytes_i,
  input  logic               byte_ready_i,
  output logic               in_ready_o,
  output logic               byte_valid_o,
  output logic [BYTE_W-1:0]  byte_data_o,
  output logic               byte_last_o,
  output logic               err_o
);
  logic               busy_q, rdy_q, last_q, err_q;
  logic [FRAME_W-1:0] frame_q;
  logic [CNT_W-1:0]   remain_q;
  logic               fire;

  assign fire = busy_q & byte_ready_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      rdy_q    <= 1'b1;
      last_q   <= 1'b0;
      err_q    <= 1'b0;
      frame_q  <= '0;
      remain_q <= '0;
    end else begin
      err_q <= load_err_i;
      if (load_i) begin
        busy_q   <= 1'b1;
        rdy_q    <= 1'b0;
        frame_q  <= frame_i;
        remain_q <= nbytes_i;
        last_q   <= (nbytes_i == CNT_W'(1));
      end else if (fire) begin
        if (last_q) begin
          busy_q   <= 1'b0;
          rdy_q    <= 1'b1;
          last_q   <= 1'b0;
          remain_q <= '0;
        end else begin
          frame_q  <= frame_q << BYTE_W;
          remain_q <= remain_q - CNT_W'(1);
          last_q   <= (remain_q == CNT_W'(2));
        end
      end
    end
  end

  assign in_ready_o   = rdy_q;
  assign byte_valid_o = busy_q;
  assign byte_data_o  = frame_q[FRAME_W-1 -: BYTE_W];
  assign byte_last_o  = last_q;
  assign err_o        = err_q;
endmodule

// File: rtl/utf8_byte_serializer.sv
module utf8_byte_serializer
  import utf8_ser_pkg::*;
#(
  parameter int              CP_W   = 21,
  parameter logic [CP_W-1:0] MAX_CP = CP_W'(21'h10FFFF)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cp_valid,
  input  logic [CP_W-1:0]   cp_data,
  output logic              cp_ready,
  output logic              byte_valid,
  output logic [BYTE_W-1:0] byte_data,
  output logic              byte_last,
  input  logic              byte_ready,
  output logic              range_err
);
  logic [CNT_W-1:0]   nbytes;
  logic               too_big;
  logic [FRAME_W-1:0] frame;
  logic               accept;

  assign accept = cp_valid & cp_ready;

  utf8_len_classify #(.CP_W(CP_W), .MAX_CP(MAX_CP)) u_cls (
    .cp_i      (cp_data),
    .nbytes_o  (nbytes),
    .too_big_o (too_big)
  );

  utf8_byte_former #(.CP_W(CP_W)) u_form (
    .cp_i     (cp_data),
    .nbytes_i (nbytes),
    .frame_o  (frame)
  );

  utf8_tx_shifter u_tx (
    .clk          (clk),
    .rst          (rst),
    .load_i       (accept & ~too_big),
    .load_err_i   (accept & too_big),
    .frame_i      (frame),
    .nbytes_i     (nbytes),
    .byte_ready_i (byte_ready),
    .in_ready_o   (cp_ready),
    .byte_valid_o (byte_valid),
    .byte_data_o  (byte_data),
    .byte_last_o  (byte_last),
    .err_o        (range_err)
  );
endmodule

// File: rtl/utf8_ser_checker.sv
module utf8_ser_checker #(
  parameter int              CP_W   = 21,
  parameter logic [CP_W-1:0] MAX_CP = CP_W'(21'h10FFFF)
) (
  input logic            clk,
  input logic            rst,
  input logic            cp_valid,
  input logic [CP_W-1:0] cp_data,
  input logic            cp_ready,
  input logic            byte_valid,
  input logic [7:0]      byte_data,
  input logic            byte_last,
  input logic            byte_ready,
  input logic            range_err
);
  logic mid_q;
  always_ff @(posedge clk) begin
    if (rst) mid_q <= 1'b0;
    else if (byte_valid && byte_ready) mid_q <= !byte_last;
  end

  p_hold_stable_r9: assert property (@(posedge clk) disable iff (rst)
    byte_valid && !byte_ready |=> byte_valid && $stable(byte_data) && $stable(byte_last));

  p_input_closed_r8: assert property (@(posedge clk) disable iff (rst)
    byte_valid |-> !cp_ready);

  p_cont_prefix_r5: assert property (@(posedge clk) disable iff (rst)
    byte_valid && mid_q |-> byte_data[7:6] == 2'b10);

  p_lead_multi_r5: assert property (@(posedge clk) disable iff (rst)
    byte_valid && !mid_q && !byte_last |-> byte_data[7:6] == 2'b11);

  p_single_ascii_r1: assert property (@(posedge clk) disable iff (rst)
    byte_valid && !mid_q && byte_last |-> !byte_data[7]);

  p_err_silent_r7: assert property (@(posedge clk) disable iff (rst)
    range_err |-> !byte_valid && cp_ready);

  p_err_cause_r7: assert property (@(posedge clk) disable iff (rst)
    range_err |-> $past(cp_valid && cp_ready && (cp_data > MAX_CP)));

  p_reset_state_r10: assert property (@(posedge clk)
    $past(rst) |-> cp_ready && !byte_valid && !range_err);
endmodule

bind utf8_byte_serializer utf8_ser_checker #(.CP_W(CP_W), .MAX_CP(MAX_CP)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cp_valid   (cp_valid),
  .cp_data    (cp_data),
  .cp_ready   (cp_ready),
  .byte_valid (byte_valid),
  .byte_data  (byte_data),
  .byte_last  (byte_last),
  .byte_ready (byte_ready),
  .range_err  (range_err)
);

// File: tb/sim_utf8_byte_serializer.sv
module sim_utf8_byte_serializer;
  localparam int CLK_PERIOD = 10;
  localparam int CP_W = 21;
  localparam int WD_LIMIT = 150000;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            cp_valid = 1'b0;
  logic [CP_W-1:0] cp_data = '0;
  logic            cp_ready;
  logic            byte_valid;
  logic [7:0]      byte_data;
  logic            byte_last;
  logic            byte_ready = 1'b0;
  logic            range_err;

  int checks = 0;
  int fails  = 0;
  int stall_ctr = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  utf8_byte_serializer #(.CP_W(CP_W)) u0 (
    .clk(clk), .rst(rst), .cp_valid(cp_valid), .cp_data(cp_data),
    .cp_ready(cp_ready), .byte_valid(byte_valid), .byte_data(byte_data),
    .byte_last(byte_last), .byte_ready(byte_ready), .range_err(range_err)
  );

  task automatic chk(input bit ok, input string req, input int cp, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s cp=%h actual=%h expected=%h", req, cp, act, exp);
    end
  endtask

  function automatic int exp_len(input int cp);
    if (cp < 128) return 1;
    if (cp < 2048) return 2;
    if (cp < 65536) return 3;
    if (cp <= 1114111) return 4;
    return 0;
  endfunction

  function automatic int exp_byte(input int cp, input int n, input int i);
    int scale;
    scale = 1;
    for (int s = 0; s < n - 1 - i; s++) scale = scale * 64;
    if (i == 0) begin
      case (n)
        1: return cp;
        2: return 192 + cp / scale;
        3: return 224 + cp / scale;
        default: return 240 + cp / scale;
      endcase
    end
    return 128 + (cp / scale) % 64;
  endfunction

  function automatic string len_tag(input int n);
    case (n)
      1: return "R1";
      2: return "R2";
      3: return "R3";
      default: return "R4";
    endcase
  endfunction

  // Sends one code point and collects its bytes, first byte in got[31:24].
  task automatic send_cp(input int cp, input bit bp, output logic [31:0] got);
    int n;
    logic [7:0] held;
    got = '0;
    n = exp_len(cp);
    @(negedge clk);
    chk(cp_ready === 1'b1, "R8", cp, int'(cp_ready), 1);
    cp_valid = 1'b1;
    cp_data  = CP_W'(cp);
    @(negedge clk);
    cp_valid = 1'b0;
    if (n == 0) begin
      chk(range_err === 1'b1, "R7", cp, int'(range_err), 1);
      chk(byte_valid === 1'b0, "R7", cp, int'(byte_valid), 0);
      chk(cp_ready === 1'b1, "R7", cp, int'(cp_ready), 1);
      @(negedge clk);
      chk(range_err === 1'b0, "R7", cp, int'(range_err), 0);
      chk(byte_valid === 1'b0, "R7", cp, int'(byte_valid), 0);
      return;
    end
    for (int i = 0; i < n; i++) begin
      stall_ctr++;
      if (bp && (stall_ctr % 3 == 1)) begin
        byte_ready = 1'b0;
        held = byte_data;
        @(negedge clk);
        chk(byte_valid === 1'b1 && byte_data === held, "R9", cp, int'(byte_data), int'(held));
      end
      chk(byte_valid === 1'b1, len_tag(n), cp, int'(byte_valid), 1);
      chk(byte_data === 8'(exp_byte(cp, n, i)), len_tag(n), cp, int'(byte_data), exp_byte(cp, n, i));
      chk(byte_last === (i == n - 1), "R11", cp, int'(byte_last), int'(i == n - 1));
      chk(cp_ready === 1'b0, "R8", cp, int'(cp_ready), 0);
      if (n > 1) chk(byte_data[7] === 1'b1, "R5", cp, int'(byte_data), 128);
      got[31 - 8*i -: 8] = byte_data;
      byte_ready = 1'b1;
      @(negedge clk);
      byte_ready = 1'b0;
    end
    chk(byte_valid === 1'b0, "R11", cp, int'(byte_valid), 0);
    chk(cp_ready === 1'b1, "R8", cp, int'(cp_ready), 1);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WD_LIMIT) begin
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] got;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cp_ready === 1'b1, "R10", 0, int'(cp_ready), 1);
    chk(byte_valid === 1'b0, "R10", 0, int'(byte_valid), 0);
    chk(range_err === 1'b0, "R10", 0, int'(range_err), 0);

    for (int cp = 0; cp < 2048; cp++) send_cp(cp, cp[0], got);
    for (int cp = 2048; cp < 65536; cp += 119) send_cp(cp, cp[1], got);
    send_cp(65535, 1'b1, got);
    for (int cp = 65536; cp <= 1114111; cp += 4951) send_cp(cp, cp[2], got);
    send_cp(1114111, 1'b1, got);

    send_cp(32'h4EAC, 1'b1, got);
    chk(got[31:8] === 24'hE4BAAC, "R6", 32'h4EAC, int'(got[31:8]), 32'hE4BAAC);

    send_cp(32'h110000, 1'b0, got);
    send_cp(32'h110000, 1'b0, got);
    send_cp(32'h1FFFFF, 1'b0, got);
    send_cp(32'h7F, 1'b1, got);
    send_cp(32'h150000, 1'b0, got);
    send_cp(32'h800, 1'b1, got);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule